// File: doc/BRIEF.md
# UART Receive Idle Timeout Interrupt

This block watches a UART receive FIFO and raises an interrupt when characters sit in the FIFO with no new traffic on the line. It counts bit-period ticks supplied by the baud generator. The count runs only while the FIFO holds data. It restarts whenever a character lands in the FIFO, whenever the FIFO is read, and whenever software clears the interrupt. Once the count reaches 32 bit periods, a status flag is set and stays set.

The flag drops for one of two reasons. The first is that the FIFO drains to empty. The second is that software writes one to the clear strobe. The raw flag is always visible. The interrupt output is the raw flag gated by an enable bit. A driver that moves data by DMA keeps the line interactive this way: short bursts that never reach a watermark are still reported.

The control is a three-state machine:
- `ST_DRAINED`: the FIFO is empty, the counter is held at zero and the flag is clear.
- `ST_WAITING`: the FIFO holds data, the counter is running and the flag is clear.
- `ST_EXPIRED`: the flag is set.

The transitions are:
- DRAINED→WAITING when the FIFO becomes non-empty.
- WAITING→EXPIRED when the idle count completes.
- EXPIRED→WAITING on a software clear.
- Any state→DRAINED when the FIFO is empty.

Top module: `uart_rx_timeout_irq`

## Requirements
- R1: After reset (`rst_n` low, active low), `rto_raw` and `rto_irq` are both 0.
- R2: With the FIFO non-empty (`fifo_empty`=0) and no restart event, `rto_raw` goes to 1 in the clock cycle after the 32nd `bit_tick` pulse is sampled. After 31 pulses it is still 0. Clock cycles without `bit_tick` do not advance the count.
- R3: A `char_rcvd` pulse restarts the idle count from zero, so a fresh 32 ticks are needed.
- R4: A `fifo_rd` pulse restarts the idle count from zero.
- R5: While `fifo_empty`=1, ticks are not counted and `rto_raw` stays 0.
- R6: `fifo_empty`=1 clears `rto_raw` on the next clock edge.
- R7: A `rto_clr` pulse clears `rto_raw` on the next edge. The flag can return only after a further full 32 ticks with the FIFO non-empty.
- R8: When the 32nd tick and `rto_clr` arrive in the same cycle, the clear wins and `rto_raw` stays 0.
- R9: `rto_irq` equals `rto_raw` AND `rto_mask`. `rto_raw` does not depend on `rto_mask`.
- R10: Once set, `rto_raw` stays 1 through ticks, `char_rcvd` and `fifo_rd` until the FIFO empties or a clear arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle pulse per received bit period |
| char_rcvd | input | 1 | Pulse: a character was written into the FIFO |
| fifo_empty | input | 1 | Level: receive FIFO is empty |
| fifo_rd | input | 1 | Pulse: a character was read from the FIFO |
| rto_mask | input | 1 | Interrupt enable (1 = pass status to output) |
| rto_clr | input | 1 | Write-one-to-clear pulse for the timeout status |
| rto_raw | output | 1 | Latched raw timeout status |
| rto_irq | output | 1 | Masked timeout interrupt |

## Verification
The assertions check the following on every cycle:
- the gating of the output by the enable bit;
- that an empty FIFO or a clear leaves the flag low on the next edge;
- that a restart event cannot set the flag;
- that the flag only rises after a tick;
- that the flag holds while nothing clears it.

Only the bench's scenarios can show the exact length of the idle window: 31 ticks are not enough and 32 are. They also show that a clear, a received character or a read really restarts the full window. The same applies to the clear winning in the cycle of the 32nd tick. These need a count of ticks across many cycles, which the bench model tracks.

// File: rtl/uart_rto_pkg.sv
package uart_rto_pkg;
    typedef enum logic [1:0] {
        ST_DRAINED = 2'd0,
        ST_WAITING = 2'd1,
        ST_EXPIRED = 2'd2
    } rto_state_t;
endpackage

// File: rtl/uart_rto_idle_cnt.sv
module uart_rto_idle_cnt #(
    parameter int IDLE_LIMIT = 32,
    localparam int CNT_W = $clog2(IDLE_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic bit_tick,
    output logic expire
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(IDLE_LIMIT - 1);
    localparam logic [CNT_W-1:0] SAT_CNT  = CNT_W'(IDLE_LIMIT);

    logic [CNT_W-1:0] idle_cnt;

    // The expiry pulse fires on the tick that completes the window.
    always_comb begin
        expire = !restart && bit_tick && (idle_cnt == LAST_CNT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_cnt <= '0;
        end else if (restart) begin
            idle_cnt <= '0;
        end else if (bit_tick && idle_cnt != SAT_CNT) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/uart_rto_fsm.sv
module uart_rto_fsm
    import uart_rto_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fifo_empty,
    input  logic expire,
    input  logic sw_clear,
    output logic status
);
    rto_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        if (fifo_empty) begin
            state_nx = ST_DRAINED;
        end else begin
            unique case (state)
                ST_DRAINED: state_nx = ST_WAITING;
                ST_WAITING: if (expire && !sw_clear) state_nx = ST_EXPIRED;
                ST_EXPIRED: if (sw_clear) state_nx = ST_WAITING;
                default:    state_nx = ST_DRAINED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_DRAINED;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_EXPIRED: status = 1'b1;
            default:    status = 1'b0;
        endcase
    end
endmodule

// File: rtl/uart_rx_timeout_irq.sv
module uart_rx_timeout_irq #(
    parameter int IDLE_LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic char_rcvd,
    input  logic fifo_empty,
    input  logic fifo_rd,
    input  logic rto_mask,
    input  logic rto_clr,
    output logic rto_raw,
    output logic rto_irq
);
    logic restart;
    logic expire;

    // Any sign of activity, an empty FIFO or a software clear restarts the window.
    assign restart = fifo_empty | char_rcvd | fifo_rd | rto_clr;

    uart_rto_idle_cnt #(.IDLE_LIMIT(IDLE_LIMIT)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .bit_tick (bit_tick),
        .expire   (expire)
    );

    uart_rto_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_empty (fifo_empty),
        .expire     (expire),
        .sw_clear   (rto_clr),
        .status     (rto_raw)
    );

    assign rto_irq = rto_raw & rto_mask;
endmodule

// File: rtl/uart_rx_timeout_irq_chk.sv
module uart_rx_timeout_irq_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic char_rcvd,
    input logic fifo_empty,
    input logic fifo_rd,
    input logic rto_mask,
    input logic rto_clr,
    input logic rto_raw,
    input logic rto_irq
);
    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !rto_raw); // R1
    AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n) !rto_mask |-> !rto_irq); // R9
    AST_MASK_PASSES: assert property (@(posedge clk) disable iff (!rst_n) (rto_mask && rto_raw) |-> rto_irq); // R9
    AST_EMPTY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) fifo_empty |=> !rto_raw); // R6
    AST_CLR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) rto_clr |=> !rto_raw); // R7
    AST_CHAR_NO_SET: assert property (@(posedge clk) disable iff (!rst_n) (char_rcvd && !rto_raw) |=> !rto_raw); // R3
    AST_READ_NO_SET: assert property (@(posedge clk) disable iff (!rst_n) (fifo_rd && !rto_raw) |=> !rto_raw); // R4
    AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) (!rto_raw && !bit_tick) |=> !rto_raw); // R2
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (rto_raw && !fifo_empty && !rto_clr) |=> rto_raw); // R10
endmodule

bind uart_rx_timeout_irq uart_rx_timeout_irq_chk u_chk (.*);

// File: tb/uart_rx_timeout_irq_test.sv
`timescale 1ns/1ps
module uart_rx_timeout_irq_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 1'b0, char_rcvd = 1'b0, fifo_empty = 1'b1, fifo_rd = 1'b0;
    logic rto_mask = 1'b1, rto_clr = 1'b0;
    logic rto_raw, rto_irq;

    int n_cmp = 0;
    int n_bad = 0;
    int m_ticks = 0;      // ticks since last restart
    bit m_flag = 1'b0;    // expected raw flag
    string tag = "R1";
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    uart_rx_timeout_irq uut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .char_rcvd(char_rcvd),
        .fifo_empty(fifo_empty), .fifo_rd(fifo_rd), .rto_mask(rto_mask),
        .rto_clr(rto_clr), .rto_raw(rto_raw), .rto_irq(rto_irq)
    );

    task automatic compare(string t);
        bit exp_irq;
        exp_irq = m_flag & rto_mask;
        n_cmp++;
        if (rto_raw !== m_flag || rto_irq !== exp_irq) begin
            n_bad++;
            $display("FAIL %s raw=%0b exp=%0b irq=%0b exp=%0b at %0t",
                     t, rto_raw, m_flag, rto_irq, exp_irq, $time);
        end
    endtask

    task automatic expect_raw(bit e, string t);
        n_cmp++;
        if (rto_raw !== e || rto_irq !== (e & rto_mask)) begin
            n_bad++;
            $display("FAIL %s raw=%0b exp=%0b irq=%0b exp=%0b",
                     t, rto_raw, e, rto_irq, e & rto_mask);
        end
    endtask

    // One clock: drive at negedge, update model at posedge, compare at next negedge.
    task automatic cyc(bit tk, bit ch, bit rd, bit clr);
        bit restart;
        bit hit;
        bit_tick = tk; char_rcvd = ch; fifo_rd = rd; rto_clr = clr;
        @(posedge clk);
        restart = fifo_empty || ch || rd || clr;
        hit = 1'b0;
        if (restart) m_ticks = 0;
        else if (tk) begin
            m_ticks++;
            if (m_ticks == 32) hit = 1'b1;
        end
        if (fifo_empty || clr) m_flag = 1'b0;
        else if (hit) m_flag = 1'b1;
        @(negedge clk);
        compare(tag);
        bit_tick = 1'b0; char_rcvd = 1'b0; fifo_rd = 1'b0; rto_clr = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            cyc(1'b1, 1'b0, 1'b0, 1'b0);
            cyc(1'b0, 1'b0, 1'b0, 1'b0);
            cyc(1'b0, 1'b0, 1'b0, 1'b0);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired in %s raw=%0b exp=%0b", tag, rto_raw, m_flag);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        expect_raw(1'b0, "R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        expect_raw(1'b0, "R1 after reset");

        // R2: exact window length; no count without ticks
        tag = "R2"; fifo_empty = 1'b0;
        ticks(31);
        for (int i = 0; i < 10; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0);
        expect_raw(1'b0, "R2 31 ticks");
        ticks(1);
        expect_raw(1'b1, "R2 32 ticks");

        // R9: masking
        tag = "R9"; rto_mask = 1'b0; cyc(1'b0, 1'b0, 1'b0, 1'b0);
        expect_raw(1'b1, "R9 masked raw");
        rto_mask = 1'b1; #0.1;
        expect_raw(1'b1, "R9 unmasked");

        // R10: sticky through activity
        tag = "R10";
        cyc(1'b0, 1'b1, 1'b0, 1'b0); cyc(1'b0, 1'b0, 1'b1, 1'b0); ticks(5);
        expect_raw(1'b1, "R10 sticky");

        // R7: clear then full window again
        tag = "R7"; cyc(1'b0, 1'b0, 1'b0, 1'b1);
        expect_raw(1'b0, "R7 cleared");
        ticks(31); expect_raw(1'b0, "R7 31 after clear");
        ticks(1);  expect_raw(1'b1, "R7 refire");

        // R6 and R5: drain clears, empty holds counter
        tag = "R6"; fifo_empty = 1'b1; cyc(1'b0, 1'b0, 1'b0, 1'b0);
        expect_raw(1'b0, "R6 drained");
        tag = "R5"; ticks(40); expect_raw(1'b0, "R5 empty no count");
        fifo_empty = 1'b0; ticks(31); expect_raw(1'b0, "R5 31 after refill");
        ticks(1); expect_raw(1'b1, "R5 window after refill");

        // R3: received character restarts
        tag = "R3"; cyc(1'b0, 1'b0, 1'b0, 1'b1);
        ticks(20); cyc(1'b0, 1'b1, 1'b0, 1'b0);
        ticks(31); expect_raw(1'b0, "R3 restarted");
        ticks(1);  expect_raw(1'b1, "R3 full window");

        // R4: read restarts
        tag = "R4"; cyc(1'b0, 1'b0, 1'b0, 1'b1);
        ticks(20); cyc(1'b0, 1'b0, 1'b1, 1'b0);
        ticks(31); expect_raw(1'b0, "R4 restarted");
        ticks(1);  expect_raw(1'b1, "R4 full window");

        // R8: clear in the same cycle as the 32nd tick
        tag = "R8"; cyc(1'b0, 1'b0, 1'b0, 1'b1);
        ticks(31); cyc(1'b1, 1'b0, 1'b0, 1'b1);
        expect_raw(1'b0, "R8 clear wins");
        ticks(31); expect_raw(1'b0, "R8 31 after");
        ticks(1);  expect_raw(1'b1, "R8 full window");

        // Mixed traffic against the model
        tag = "R2 mixed";
        for (int i = 0; i < 20000; i++) begin
            int r;
            r = $urandom_range(0, 999);
            if (r < 3) fifo_empty = ~fifo_empty;
            if (r >= 500 && r < 510) rto_mask = ~rto_mask;
            cyc(r[1:0] == 2'b00 || r > 900, r == 100, r == 200, r == 300);
        end
        finish_run();
    end
endmodule